// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a single-channel voltage DAC. A host writes 24- or 32-bit words into a shift register over a three-wire serial link: a serial clock, a data line and an active-low select/load pin. When the select pin rises, the block decodes a 4-bit command from the word. The command can load a staging register, copy the staging register into the live DAC register, do both in one step, or put the converter into power-down. The live register value and a powered-down flag drive the analog core, which is outside this block.

There are also three side pins. A level-sensitive clear pin forces both registers to a build-time clear value, which is zero or midscale. A load pin copies the staging register into the live register, either at once or deferred to the end of the frame, and it also holds the converter powered up. A serial output repeats the incoming data 32 clock edges later so that several devices can share one link in a chain.

All pins are sampled by a system clock `clk`. The serial clock is treated as a slow data signal whose edges are detected in that clock domain.

Top module: `dac_serial_frontend`

## Requirements
- R1: During and after reset, `dac_code` equals the clear value (zero when `CLEAR_MID`=0, `1<<(CODE_BITS-1)` when `CLEAR_MID`=1), `powered_down` is 0 and `sdo` is 0.
- R2: A bit of `sdi` is shifted in only on a rising `sck` edge while `cs_n` is low. `sck` activity while `cs_n` is high leaves the shift register and `sdo` unchanged.
- R3: A word may be 24 or 32 bits long, MSB first. The command comes from bits 23..20 of the last 24 bits shifted in, and the 16-bit data field from bits 15..0. The word length is not checked, so a select pulse with no clocks runs the stale content again.
- R4: Command 4'b0000 loads the staging register only. `dac_code` does not change.
- R5: Command 4'b0001 copies the staging register to `dac_code` and clears `powered_down`.
- R6: Command 4'b0011 loads the data field into both registers and clears `powered_down`.
- R7: Command 4'b0100 sets `powered_down` and leaves both registers unchanged. The flag rises only on a select rise while `ldac_n` is high.
- R8: Command 4'b1111 and every other unlisted code change nothing.
- R9: `sdo` updates only on a falling `sck` edge while `cs_n` is low. It shows the bit that entered 31 rising edges before that edge's rise, so each bit leaves 32 rising edges after it entered.
- R10: While `clr_n` is low, both registers are forced to the clear value, and a pending load is dropped.
- R11: A falling `ldac_n` edge while `cs_n` is high copies the staging register to `dac_code` and clears `powered_down`.
- R12: A falling `ldac_n` edge while `cs_n` is low leaves `dac_code` unchanged until `cs_n` rises. The copy then happens after that frame's command has run.
- R13: While `ldac_n` is low, `powered_down` is cleared, and a power-down command in a frame that ends with `ldac_n` low has no effect.
- R14: With `CODE_BITS` below 16, the code is taken from the top `CODE_BITS` of the data field and the low bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select; its rise executes the word |
| ldac_n | input | 1 | Active-low load pin |
| clr_n | input | 1 | Active-low level clear |
| sdo | output | 1 | Chained serial data out |
| dac_code | output | CODE_BITS | Live DAC register |
| powered_down | output | 1 | Converter power-down state |

## Verification
The bench targets the following corner cases:

- **Load pulse inside an open frame.** A design that copied at once would show the old staging value in the middle of the frame.
- **Power-down while the load pin is held low.** A design without the suppression would raise the power-down flag.
- **Select pulse with no clock edges.** It must re-run the stale word. A design that shifts on `sck` while deselected would decode a corrupted command and update the output.
- **Chained output across two back-to-back 32-bit words.** An off-by-one in the delay shifts every observed bit.
- **12-bit instance with a midscale clear.** It catches wrong slicing of the data field and a wrong clear value.

// File: rtl/dac_fe_pkg.sv
// Package: shared command codes and word field positions for the DAC
// serial front end. Assumes the command sits in the last 24 bits of a word.
package dac_fe_pkg;
    localparam int CORE_BITS = 24;
    localparam int CMD_HI    = 23;
    localparam int CMD_LO    = 20;
    localparam int FIELD_W   = 16;

    typedef enum logic [3:0] {
        CMD_LOAD_STAGE = 4'b0000,
        CMD_COMMIT     = 4'b0001,
        CMD_LOAD_BOTH  = 4'b0011,
        CMD_SLEEP      = 4'b0100,
        CMD_IDLE       = 4'b1111
    } cmd_e;

    // Clear value for a register of the given width.
    function automatic logic [FIELD_W-1:0] clear_code(input int bits, input bit mid);
        logic [FIELD_W-1:0] v;
        v = '0;
        if (mid) v[bits-1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/dac_fe_pin_edge.sv
// Module: registers a group of pins once per clock and reports rising and
// falling edges against the previous sample. Assumes pins are already
// synchronous to clk or changed far from its edges.
module dac_fe_pin_edge #(
    parameter int              W         = 3,
    parameter logic [W-1:0]    RST_LEVEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] prev,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // Hold the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_LEVEL;
        else        prev <= pins;
    end

    // Edge flags compare the live pin with its previous sample.
    always_comb begin
        rise = pins & ~prev;
        fall = ~pins & prev;
    end
endmodule

// File: rtl/dac_fe_shifter.sv
// Module: serial input shift register with chained output. Shifts on a
// detected serial-clock rise while selected and moves the top bit to sdo on
// the following detected fall. Assumes SHIFT_BITS >= 24.
module dac_fe_shifter #(
    parameter int SHIFT_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  sdi,
    output logic [SHIFT_BITS-1:0] word,
    output logic                  sdo
);
    // Shift a new bit in at the bottom on each selected rise.
    always_ff @(posedge clk) begin
        if (!rst_n)                word <= '0;
        else if (sel && sck_rise)  word <= {word[SHIFT_BITS-2:0], sdi};
    end

    // Present the oldest bit on each selected fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                sdo <= 1'b0;
        else if (sel && sck_fall)  sdo <= word[SHIFT_BITS-1];
    end
endmodule

// File: rtl/dac_fe_regs.sv
// Module: command decoder with the double-buffered staging and live
// registers, load-pin rules and power-down flag. Assumes one event set per
// clock; clear wins over everything else on the registers.
module dac_fe_regs
    import dac_fe_pkg::*;
#(
    parameter int CODE_BITS = 16,
    parameter bit CLEAR_MID = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CORE_BITS-1:0] core,
    input  logic                 cs_rise,
    input  logic                 cs_low_q,
    input  logic                 ldac_fall,
    input  logic                 ldac_n,
    input  logic                 clr_n,
    output logic [CODE_BITS-1:0] live_code,
    output logic                 sleep
);
    localparam logic [FIELD_W-1:0]   CLR_FULL = clear_code(CODE_BITS, CLEAR_MID);
    localparam logic [CODE_BITS-1:0] CLR_VAL  = CLR_FULL[CODE_BITS-1:0];

    logic [CODE_BITS-1:0] stage_q, stage_d, live_d;
    logic                 sleep_d, pend_q, pend_d, pend_eff;
    logic [CODE_BITS-1:0] field_code;
    cmd_e                 cmd;

    // Slice the command and the top CODE_BITS of the data field.
    always_comb begin
        cmd        = cmd_e'(core[CMD_HI:CMD_LO]);
        field_code = core[FIELD_W-1 -: CODE_BITS];
        pend_eff   = pend_q | (ldac_fall & cs_low_q);
    end

    // Next-state rules for both registers, the pending load and power state.
    always_comb begin
        stage_d = stage_q;
        live_d  = live_code;
        sleep_d = sleep;
        pend_d  = pend_q;
        if (cs_rise) begin
            case (cmd)
                CMD_LOAD_STAGE: stage_d = field_code;
                CMD_COMMIT:     begin live_d = stage_q; sleep_d = 1'b0; end
                CMD_LOAD_BOTH:  begin stage_d = field_code; live_d = field_code; sleep_d = 1'b0; end
                CMD_SLEEP:      if (ldac_n) sleep_d = 1'b1;
                default:        ;
            endcase
            if (pend_eff) begin
                live_d  = stage_d;
                sleep_d = 1'b0;
                pend_d  = 1'b0;
            end
        end else if (ldac_fall && cs_low_q) begin
            pend_d = 1'b1;
        end else if (ldac_fall) begin
            live_d  = stage_q;
            sleep_d = 1'b0;
        end
        if (!ldac_n) sleep_d = 1'b0;
        if (!clr_n) begin
            stage_d = CLR_VAL;
            live_d  = CLR_VAL;
            pend_d  = 1'b0;
        end
    end

    // Register update with synchronous reset to the clear value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= CLR_VAL;
            live_code <= CLR_VAL;
            sleep     <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            stage_q   <= stage_d;
            live_code <= live_d;
            sleep     <= sleep_d;
            pend_q    <= pend_d;
        end
    end
endmodule

// File: rtl/dac_serial_frontend.sv
// Module: top of the DAC serial command interface. Samples the pins with
// clk, shifts serial words, executes commands on select rise and drives the
// live code, power-down flag and chained output. Assumes pin edges are at
// least one clk period apart.
module dac_serial_frontend
    import dac_fe_pkg::*;
#(
    parameter int CODE_BITS  = 16,
    parameter bit CLEAR_MID  = 1'b0,
    parameter int SHIFT_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 sdi,
    input  logic                 cs_n,
    input  logic                 ldac_n,
    input  logic                 clr_n,
    output logic                 sdo,
    output logic [CODE_BITS-1:0] dac_code,
    output logic                 powered_down
);
    localparam int PIN_W = 3;
    localparam int P_SCK = 0;
    localparam int P_CS  = 1;
    localparam int P_LD  = 2;

    logic [PIN_W-1:0]      pins, pin_prev, pin_rise, pin_fall;
    logic [SHIFT_BITS-1:0] word;

    // Gather the edge-detected pins into one vector.
    always_comb pins = {ldac_n, cs_n, sck};

    dac_fe_pin_edge #(
        .W         (PIN_W),
        .RST_LEVEL (3'b110)
    ) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins),
        .prev  (pin_prev),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    dac_fe_shifter #(
        .SHIFT_BITS (SHIFT_BITS)
    ) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (~cs_n),
        .sck_rise (pin_rise[P_SCK]),
        .sck_fall (pin_fall[P_SCK]),
        .sdi      (sdi),
        .word     (word),
        .sdo      (sdo)
    );

    dac_fe_regs #(
        .CODE_BITS (CODE_BITS),
        .CLEAR_MID (CLEAR_MID)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .core      (word[CORE_BITS-1:0]),
        .cs_rise   (pin_rise[P_CS]),
        .cs_low_q  (~pin_prev[P_CS]),
        .ldac_fall (pin_fall[P_LD]),
        .ldac_n    (ldac_n),
        .clr_n     (clr_n),
        .live_code (dac_code),
        .sleep     (powered_down)
    );
endmodule

// File: rtl/dac_fe_chk.sv
// Module: assertion checker bound to dac_serial_frontend. Observes ports
// only and relates outputs to the pin history.
module dac_fe_chk
    import dac_fe_pkg::*;
#(
    parameter int CODE_BITS = 16,
    parameter bit CLEAR_MID = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sck,
    input logic                 cs_n,
    input logic                 ldac_n,
    input logic                 clr_n,
    input logic                 sdo,
    input logic [CODE_BITS-1:0] dac_code,
    input logic                 powered_down
);
    localparam logic [FIELD_W-1:0]   CF   = clear_code(CODE_BITS, CLEAR_MID);
    localparam logic [CODE_BITS-1:0] CVAL = CF[CODE_BITS-1:0];

    assert_sdo_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> (!$past(sck) && $past(sck, 2) && !$past(cs_n)));

    assert_sdo_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(sdo));

    assert_sleep_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_down) |-> ($past(cs_n) && !$past(cs_n, 2) && $past(ldac_n)));

    assert_ldac_wakes_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |=> !powered_down);

    assert_clear_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (dac_code == CVAL));

    assert_live_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> (($past(cs_n) && !$past(cs_n, 2)) ||
                                (!$past(ldac_n) && $past(ldac_n, 2)) ||
                                !$past(clr_n)));
endmodule

bind dac_serial_frontend dac_fe_chk #(
    .CODE_BITS (CODE_BITS),
    .CLEAR_MID (CLEAR_MID)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck          (sck),
    .cs_n         (cs_n),
    .ldac_n       (ldac_n),
    .clr_n        (clr_n),
    .sdo          (sdo),
    .dac_code     (dac_code),
    .powered_down (powered_down)
);

// File: tb/dac_serial_frontend_tb_top.sv
// Bench: scoreboard for two instances (16-bit zero clear, 12-bit midscale
// clear) sharing the pins. Driver tasks push expected items; a monitor
// process pops and compares them.
module dac_serial_frontend_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, cs_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
    logic sdo, sdo12, pd, pd12;
    logic [15:0] code16;
    logic [11:0] code12;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_frontend #(.CODE_BITS(16), .CLEAR_MID(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
        .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .dac_code(code16),
        .powered_down(pd));

    dac_serial_frontend #(.CODE_BITS(12), .CLEAR_MID(1'b1)) dut12_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
        .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo12), .dac_code(code12),
        .powered_down(pd12));

    typedef struct {
        string       tag;
        logic [15:0] e16;
        logic [11:0] e12;
        logic        epd;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_chk = 0, n_err = 0;

    // Reference model state derived from the requirements.
    logic [15:0] m_in16 = 16'h0, m_dac16 = 16'h0;
    logic [11:0] m_in12 = 12'h800, m_dac12 = 12'h800;
    logic        m_pd = 1'b0, m_pend = 1'b0;
    logic [31:0] m_sr = '0;
    logic        seen [0:31];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_now(input string tag);
        exp_t it;
        it.tag = tag; it.e16 = m_dac16; it.e12 = m_dac12; it.epd = m_pd;
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    // Monitor: pop expected items and compare against the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check(code16 == it.e16, {it.tag, " code16"}, 32'(code16), 32'(it.e16));
                check(code12 == it.e12, {it.tag, " code12"}, 32'(code12), 32'(it.e12));
                check(pd == it.epd && pd12 == it.epd, {it.tag, " pd"}, 32'({pd, pd12}), 32'({it.epd, it.epd}));
            end
        end
    end

    task automatic model_exec(input logic [3:0] c, input logic [15:0] d);
        case (c)
            4'b0000: begin m_in16 = d; m_in12 = d[15:4]; end
            4'b0001: begin m_dac16 = m_in16; m_dac12 = m_in12; m_pd = 1'b0; end
            4'b0011: begin m_in16 = d; m_in12 = d[15:4]; m_dac16 = d; m_dac12 = d[15:4]; m_pd = 1'b0; end
            4'b0100: if (ldac_n) m_pd = 1'b1;
            default: ;
        endcase
        if (m_pend) begin m_dac16 = m_in16; m_dac12 = m_in12; m_pd = 1'b0; m_pend = 1'b0; end
        if (!ldac_n) m_pd = 1'b0;
    endtask

    // Driver: one serial word of n bits; optional load pulse after bit ldac_at.
    task automatic frame(input int n, input logic [31:0] w, input int ldac_at);
        cs_n = 1'b0; tick(2);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = w[i]; tick(1);
            sck = 1'b1; tick(2);
            sck = 1'b0; tick(2);
            seen[n-1-i] = sdo;
            check(sdo == sdo12, "R9 chained outputs agree", 32'(sdo), 32'(sdo12));
            if (n - 1 - i == ldac_at) begin
                ldac_n = 1'b0; m_pend = 1'b1; m_pd = 1'b0; tick(2);
                ldac_n = 1'b1; tick(1);
                expect_now("R12 deferred load mid-frame");
            end
        end
        m_sr = (n >= 32) ? w : ((m_sr << n) | w);
        cs_n = 1'b1; tick(2);
        model_exec(m_sr[23:20], m_sr[15:0]);
    endtask

    task automatic ldac_low();
        if (cs_n) begin m_dac16 = m_in16; m_dac12 = m_in12; end
        else m_pend = 1'b1;
        m_pd = 1'b0;
        ldac_n = 1'b0; tick(2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] wa, wb;
        tick(4);
        rst_n = 1'b1; tick(2);
        expect_now("R1 reset state");
        check(sdo == 1'b0, "R1 sdo after reset", 32'(sdo), 32'h0);

        frame(24, 24'h0F1234, -1);          // R4 staging load, 24-bit word
        expect_now("R4 load stage only");
        frame(24, 24'h100000, -1);          // R5 commit; R14 top 12 bits
        expect_now("R5 R14 commit");
        frame(32, 32'hA7_30ABCD, -1);       // R3 32-bit word, junk lead byte; R6
        expect_now("R3 R6 load both");
        frame(24, 24'h40FFFF, -1);          // R7 power down, data ignored
        expect_now("R7 power down");
        frame(24, 24'h005555, -1);
        expect_now("R4 load while asleep");
        frame(24, 24'h100000, -1);
        expect_now("R5 commit wakes");
        frame(24, 24'hF00F0F, -1);          // R8 idle code
        frame(24, 24'hA00F0F, -1);          // R8 unlisted code
        expect_now("R8 no change");
        frame(24, 24'h100000, -1);
        expect_now("R8 stage untouched");

        frame(24, 24'h007777, -1);          // R11 load pin while deselected
        ldac_low(); ldac_n = 1'b1; tick(2);
        expect_now("R11 immediate load");
        frame(24, 24'h400000, -1);
        expect_now("R7 asleep again");
        ldac_low(); ldac_n = 1'b1; tick(2);
        expect_now("R11 load wakes");

        frame(24, 24'h002468, 10);          // R12 pulse inside frame
        expect_now("R12 load at select rise");

        ldac_low();                          // R13 hold low, sleep suppressed
        frame(24, 24'h400000, -1);
        expect_now("R13 sleep suppressed");
        ldac_n = 1'b1; tick(2);
        frame(24, 24'h400000, -1);
        expect_now("R13 sleep accepted");
        ldac_low();
        expect_now("R13 low level wakes");
        ldac_n = 1'b1; tick(2);

        clr_n = 1'b0; tick(2);               // R10 clear
        m_in16 = 16'h0; m_dac16 = 16'h0; m_in12 = 12'h800; m_dac12 = 12'h800; m_pend = 1'b0;
        expect_now("R10 clear value");
        clr_n = 1'b1; tick(1);
        frame(24, 24'h100000, -1);
        expect_now("R10 stage cleared");

        wa = 32'h5AF3C96E;                   // R9 chain delay across two words
        wb = 32'h3C304321;
        frame(32, wa, -1);
        check(seen[31] == wa[31], "R9 first bit out", 32'(seen[31]), 32'(wa[31]));
        frame(32, wb, -1);
        for (int j = 0; j < 31; j++)
            check(seen[j] == wa[30-j], "R9 delayed bit", 32'(seen[j]), 32'(wa[30-j]));
        expect_now("R9 second word executes");

        frame(24, 24'h001111, -1);           // R2 deselected clocks ignored
        sdi = 1'b1;
        for (int k = 0; k < 8; k++) begin
            sck = 1'b1; tick(2); sck = 1'b0; tick(2);
        end
        check(sdo == wb[7], "R2 sdo frozen", 32'(sdo), 32'(wb[7]));
        cs_n = 1'b0; tick(2); cs_n = 1'b1; tick(2);   // R3 empty frame re-runs
        model_exec(m_sr[23:20], m_sr[15:0]);
        expect_now("R2 R3 stale word rerun");

        tick(2);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule